// File: doc/BRIEF.md
# Multiplexed Address Programming Port

This block is the parallel programming front end of a flash controller. A programmer presents an 18-bit byte address in two halves on an 11-pin address bus, qualified by a single row/column strobe: the low half is taken on the strobe's falling edge and the high half on its rising edge. Separate active-low output-enable and write-enable strobes then start read and write cycles. The block turns them into single-cycle requests toward the command decoder and array access logic. Those units answer reads through a simple valid/data response.

All pin strobes are asynchronous to the fast system clock. They pass through two-flop synchronizers, and their edges are detected after synchronization. The 8-bit data bus is modelled as separate input, output and output-enable signals. The output side is enabled only while the port is active and output-enable is low with write-enable high. A ready/busy output mirrors the most significant bit of the controller's status byte.

An interface-select input is sampled once, on the first clock after reset is released. A low value leaves the port dormant until the next reset, and later changes on the input have no effect.

Top module: `mux_prog_port`

## Requirements
- R1: When a falling edge of `rc_i` is detected, `addr_pins_i[10:0]` becomes address bits [10:0]. Address bits [17:11] keep their value.
- R2: When a rising edge of `rc_i` is detected, `addr_pins_i[6:0]` becomes address bits [17:11]. Address bits [10:0] keep their value and pins [10:7] are not used.
- R3: `data_oe_o` is 1 only while the port is active, reset is released, `oe_n_i` is 0 and `we_n_i` is 1. It follows these pins with no clock delay.
- R4: A falling edge on `oe_n_i` produces a one-cycle `req_rd_o` on the third clock edge after the pin changes, with `req_addr_o` holding the current address. `data_o` keeps its previous value until the first `rsp_valid_i` of that read, then shows `rsp_rdata_i` from the following clock edge.
- R5: A rising edge on `we_n_i` produces a one-cycle `req_wr_o` on the third clock edge after the pin changes. The request carries the full 18-bit address and the `data_i` value held at that edge.
- R6: While the port is active, `rdy_o` equals `status_i[7]` delayed by one clock (1 means ready, 0 means busy). While the port is dormant or in reset, `rdy_o` is 1.
- R7: `port_sel_i` is sampled on the first clock after `rst_n` rises, and a value of 1 makes the port active. A dormant port issues no requests and never drives the bus, even if `port_sel_i` later goes high.
- R8: While `rst_n` is 0, no request is issued, `data_oe_o` is 0, `data_o` is 0 and `rdy_o` is 1. After release, the address is 0 and the port is in read mode.
- R9: If a row/column strobe edge and a write-enable or output-enable edge are detected in the same cycle, the request carries the address from before the update, and the update still takes effect.
- R10: A `rsp_valid_i` pulse that arrives with no read outstanding leaves `data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| port_sel_i | input | 1 | Interface select, sampled after reset |
| rc_i | input | 1 | Row/column address strobe |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| addr_pins_i | input | 11 | Multiplexed address pins |
| data_i | input | 8 | Data bus, input side |
| data_o | output | 8 | Data bus, output side (last read data) |
| data_oe_o | output | 1 | Data bus output enable |
| rdy_o | output | 1 | Ready (1) / busy (0) |
| req_rd_o | output | 1 | One-cycle read request |
| req_wr_o | output | 1 | One-cycle write request |
| req_addr_o | output | 18 | Request address |
| req_wdata_o | output | 8 | Write request data |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_rdata_i | input | 8 | Read response data |
| status_i | input | 8 | Controller status byte, bit 7 = ready |

## Verification
An address strobe edge and a write-enable edge can reach the synchronized side in the same clock cycle. In that case the address register and the request register load on the same edge. The bench provokes this by flipping `rc_i` low with new row pins on the same clock phase that raises `we_n_i`. It judges the result by requiring the write to carry the old address, and the next write to carry the new row bits. A second collision, a read response arriving with no read outstanding, is judged by `data_o` staying put.

// File: rtl/mpp_pkg.sv
package mpp_pkg;
    // Index of each strobe inside the synchronizer vector
    localparam int unsigned STB_RC  = 0;
    localparam int unsigned STB_OE  = 1;
    localparam int unsigned STB_WE  = 2;
    localparam int unsigned NUM_STB = 3;
endpackage

// File: rtl/mpp_sync.sv
module mpp_sync #(
    parameter int unsigned W    = 3,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = in_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{s1: IDLE, s2: IDLE, prev: IDLE};
        end else begin
            sync_q <= sync_d;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise_o[i] =  sync_q.s2[i] & ~sync_q.prev[i];
        assign fall_o[i] = ~sync_q.s2[i] &  sync_q.prev[i];
    end
endmodule

// File: rtl/mpp_addr_latch.sv
module mpp_addr_latch #(
    parameter int unsigned ROW_W = 11,
    parameter int unsigned COL_W = 7,
    localparam int unsigned AW   = ROW_W + COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [ROW_W-1:0] pins_i,
    input  logic             row_stb_i,
    input  logic             col_stb_i,
    output logic [AW-1:0]    addr_o
);
    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (en_i && row_stb_i) begin
            addr_d[ROW_W-1:0] = pins_i;
        end
        if (en_i && col_stb_i) begin
            addr_d[AW-1:ROW_W] = pins_i[COL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/mpp_cycle_ctrl.sv
module mpp_cycle_ctrl #(
    parameter int unsigned AW = 18,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          rd_stb_i,
    input  logic          wr_stb_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rsp_valid_i,
    input  logic [DW-1:0] rsp_rdata_i,
    input  logic          ready_bit_i,
    output logic          req_rd_o,
    output logic          req_wr_o,
    output logic [AW-1:0] req_addr_o,
    output logic [DW-1:0] req_wdata_o,
    output logic [DW-1:0] rdata_o,
    output logic          rdy_o
);
    typedef struct packed {
        logic          req_rd;
        logic          req_wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          pend;
        logic [DW-1:0] rdata;
        logic          rdy;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d        = ctrl_q;
        ctrl_d.req_rd = 1'b0;
        ctrl_d.req_wr = 1'b0;
        ctrl_d.rdy    = active_i ? ready_bit_i : 1'b1;

        // Response for the outstanding read lands first
        if (ctrl_q.pend && rsp_valid_i) begin
            ctrl_d.rdata = rsp_rdata_i;
            ctrl_d.pend  = 1'b0;
        end

        if (active_i && wr_stb_i) begin
            ctrl_d.req_wr = 1'b1;
            ctrl_d.addr   = addr_i;
            ctrl_d.wdata  = wdata_i;
        end

        if (active_i && rd_stb_i) begin
            ctrl_d.req_rd = 1'b1;
            ctrl_d.addr   = addr_i;
            ctrl_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ctrl_q.rdy <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_rd_o    = ctrl_q.req_rd;
    assign req_wr_o    = ctrl_q.req_wr;
    assign req_addr_o  = ctrl_q.addr;
    assign req_wdata_o = ctrl_q.wdata;
    assign rdata_o     = ctrl_q.rdata;
    assign rdy_o       = ctrl_q.rdy;
endmodule

// File: rtl/mux_prog_port.sv
module mux_prog_port #(
    parameter int unsigned AP_W  = 11,
    parameter int unsigned COL_W = 7,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = AP_W + COL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            port_sel_i,
    input  logic            rc_i,
    input  logic            oe_n_i,
    input  logic            we_n_i,
    input  logic [AP_W-1:0] addr_pins_i,
    input  logic [DW-1:0]   data_i,
    output logic [DW-1:0]   data_o,
    output logic            data_oe_o,
    output logic            rdy_o,
    output logic            req_rd_o,
    output logic            req_wr_o,
    output logic [AW-1:0]   req_addr_o,
    output logic [DW-1:0]   req_wdata_o,
    input  logic            rsp_valid_i,
    input  logic [DW-1:0]   rsp_rdata_i,
    input  logic [DW-1:0]   status_i
);
    import mpp_pkg::*;

    localparam int unsigned READY_BIT = DW - 1;

    typedef struct packed {
        logic armed;
        logic active;
    } mode_t;

    mode_t mode_d, mode_q;

    logic [NUM_STB-1:0] stb_raw;
    logic [NUM_STB-1:0] stb_rise;
    logic [NUM_STB-1:0] stb_fall;
    logic [AW-1:0]      addr_cur;
    logic               unused_sig;

    assign stb_raw[STB_RC] = rc_i;
    assign stb_raw[STB_OE] = oe_n_i;
    assign stb_raw[STB_WE] = we_n_i;

    // Interface select is taken once, on the first clock after reset
    always_comb begin
        mode_d = mode_q;
        if (mode_q.armed) begin
            mode_d.active = port_sel_i;
            mode_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{armed: 1'b1, active: 1'b0};
        end else begin
            mode_q <= mode_d;
        end
    end

    mpp_sync #(
        .W    (NUM_STB),
        .IDLE ('1)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (stb_raw),
        .rise_o (stb_rise),
        .fall_o (stb_fall)
    );

    mpp_addr_latch #(
        .ROW_W (AP_W),
        .COL_W (COL_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (mode_q.active),
        .pins_i    (addr_pins_i),
        .row_stb_i (stb_fall[STB_RC]),
        .col_stb_i (stb_rise[STB_RC]),
        .addr_o    (addr_cur)
    );

    mpp_cycle_ctrl #(
        .AW (AW),
        .DW (DW)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (mode_q.active),
        .rd_stb_i    (stb_fall[STB_OE]),
        .wr_stb_i    (stb_rise[STB_WE]),
        .addr_i      (addr_cur),
        .wdata_i     (data_i),
        .rsp_valid_i (rsp_valid_i),
        .rsp_rdata_i (rsp_rdata_i),
        .ready_bit_i (status_i[READY_BIT]),
        .req_rd_o    (req_rd_o),
        .req_wr_o    (req_wr_o),
        .req_addr_o  (req_addr_o),
        .req_wdata_o (req_wdata_o),
        .rdata_o     (data_o),
        .rdy_o       (rdy_o)
    );

    // Bus drive follows the pins directly so release is immediate
    assign data_oe_o = rst_n & mode_q.active & ~oe_n_i & we_n_i;

    assign unused_sig = &{1'b0, stb_rise[STB_OE], stb_fall[STB_WE],
                          status_i[READY_BIT-1:0]};
endmodule

// File: rtl/mux_prog_port_chk.sv
module mux_prog_port_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          active,
    input logic          armed,
    input logic          oe_n_i,
    input logic          we_n_i,
    input logic          data_oe_o,
    input logic [DW-1:0] data_o,
    input logic          rdy_o,
    input logic          req_rd_o,
    input logic          req_wr_o,
    input logic          rsp_valid_i,
    input logic [DW-1:0] status_i
);
    p_drive_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (!oe_n_i && we_n_i && active));

    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd_o |=> !req_rd_o);

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_i |=> $stable(data_o));

    p_wr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr_o |=> !req_wr_o);

    p_rdy_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (rdy_o == $past(status_i[DW-1])));

    p_rdy_dormant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !$past(active)) |-> rdy_o);

    p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> $stable(active));

    p_dormant_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!req_rd_o && !req_wr_o));
endmodule

bind mux_prog_port mux_prog_port_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (mode_q.active),
    .armed       (mode_q.armed),
    .oe_n_i      (oe_n_i),
    .we_n_i      (we_n_i),
    .data_oe_o   (data_oe_o),
    .data_o      (data_o),
    .rdy_o       (rdy_o),
    .req_rd_o    (req_rd_o),
    .req_wr_o    (req_wr_o),
    .rsp_valid_i (rsp_valid_i),
    .status_i    (status_i)
);

// File: tb/mux_prog_port_test.sv
`timescale 1ns/1ps
module mux_prog_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_sel_i = 1'b1;
    logic        rc_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic        we_n_i = 1'b1;
    logic [10:0] addr_pins_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  data_o;
    logic        data_oe_o;
    logic        rdy_o;
    logic        req_rd_o;
    logic        req_wr_o;
    logic [17:0] req_addr_o;
    logic [7:0]  req_wdata_o;
    logic        rsp_valid_i = 1'b0;
    logic [7:0]  rsp_rdata_i = '0;
    logic [7:0]  status_i = 8'h80;

    int checks = 0;
    int failures = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [17:0] wr_addr_cap;
    logic [7:0]  wr_data_cap;
    logic [17:0] rd_addr_cap;
    bit done = 0;

    always #2.5 clk = ~clk;

    mux_prog_port uut (
        .clk(clk), .rst_n(rst_n), .port_sel_i(port_sel_i), .rc_i(rc_i),
        .oe_n_i(oe_n_i), .we_n_i(we_n_i), .addr_pins_i(addr_pins_i),
        .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
        .rdy_o(rdy_o), .req_rd_o(req_rd_o), .req_wr_o(req_wr_o),
        .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
        .rsp_valid_i(rsp_valid_i), .rsp_rdata_i(rsp_rdata_i),
        .status_i(status_i)
    );

    // Request monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (req_wr_o) begin
            wr_cnt++;
            wr_addr_cap = req_addr_o;
            wr_data_cap = req_wdata_o;
        end
        if (req_rd_o) begin
            rd_cnt++;
            rd_addr_cap = req_addr_o;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic [10:0] row, input logic [10:0] col);
        addr_pins_i = row; rc_i = 1'b0; step(4);
        addr_pins_i = col; rc_i = 1'b1; step(4);
    endtask

    task automatic do_write(input logic [7:0] d);
        data_i = d; we_n_i = 1'b0; step(4);
        we_n_i = 1'b1; step(5);
    endtask

    task automatic do_reset(input logic sel);
        port_sel_i = sel;
        rst_n = 1'b0; oe_n_i = 1'b0; step(3);
        check("R8 oe in reset", {31'd0, data_oe_o}, 32'd0);
        check("R8 rdy in reset", {31'd0, rdy_o}, 32'd1);
        check("R8 data in reset", {24'd0, data_o}, 32'd0);
        check("R8 req in reset", {30'd0, req_rd_o, req_wr_o}, 32'd0);
        oe_n_i = 1'b1; rst_n = 1'b1; step(3);
    endtask

    task automatic t_reset_default();
        int w0;
        do_reset(1'b1);
        w0 = wr_cnt;
        do_write(8'h3C);
        check("R8 write count after reset", wr_cnt - w0, 32'd1);
        check("R8 address zero after reset", {14'd0, wr_addr_cap}, 32'd0);
    endtask

    task automatic t_addr_halves();
        set_addr(11'h5A3, 11'h02C);
        do_write(8'h11);
        check("R1 R2 full address", {14'd0, wr_addr_cap}, {14'd0, 7'h2C, 11'h5A3});
        addr_pins_i = 11'h0F1; rc_i = 1'b0; step(4);
        do_write(8'h12);
        check("R1 row only, column kept", {14'd0, wr_addr_cap}, {14'd0, 7'h2C, 11'h0F1});
        addr_pins_i = {4'hF, 7'h71}; rc_i = 1'b1; step(4);
        do_write(8'h13);
        check("R2 column only, row kept", {14'd0, wr_addr_cap}, {14'd0, 7'h71, 11'h0F1});
    endtask

    task automatic t_write_timing();
        int w0;
        set_addr(11'h7FF, 11'h07F);
        w0 = wr_cnt;
        data_i = 8'hA5; we_n_i = 1'b0; step(4);
        we_n_i = 1'b1; step(2);
        check("R5 no request before third edge", {31'd0, req_wr_o}, 32'd0);
        step(1);
        check("R5 request on third edge", {31'd0, req_wr_o}, 32'd1);
        check("R5 request data", {24'd0, req_wdata_o}, 32'hA5);
        check("R5 request address", {14'd0, req_addr_o}, 32'h3FFFF);
        step(1);
        check("R5 request one cycle", {31'd0, req_wr_o}, 32'd0);
        step(3);
        check("R5 single pulse count", wr_cnt - w0, 32'd1);
    endtask

    task automatic t_read();
        logic [7:0] prev;
        set_addr(11'h123, 11'h045);
        prev = data_o;
        oe_n_i = 1'b0; #1;
        check("R3 drive on oe low", {31'd0, data_oe_o}, 32'd1);
        we_n_i = 1'b0; #1;
        check("R3 no drive while we low", {31'd0, data_oe_o}, 32'd0);
        we_n_i = 1'b1;
        step(3);
        check("R4 read request", {31'd0, req_rd_o}, 32'd1);
        check("R4 read address", {14'd0, req_addr_o}, {14'd0, 7'h45, 11'h123});
        step(2);
        check("R4 data held before response", {24'd0, data_o}, {24'd0, prev});
        rsp_rdata_i = 8'h9E; rsp_valid_i = 1'b1; step(1);
        rsp_valid_i = 1'b0; rsp_rdata_i = 8'h00;
        check("R4 data after response", {24'd0, data_o}, 32'h9E);
        oe_n_i = 1'b1; #1;
        check("R3 release on oe high", {31'd0, data_oe_o}, 32'd0);
        step(4);
    endtask

    task automatic t_orphan_rsp();
        rsp_rdata_i = 8'h44; rsp_valid_i = 1'b1; step(1);
        rsp_valid_i = 1'b0; step(1);
        check("R10 orphan response ignored", {24'd0, data_o}, 32'h9E);
    endtask

    task automatic t_ready();
        status_i = 8'h7F; step(1);
        check("R6 busy follows bit7", {31'd0, rdy_o}, 32'd0);
        status_i = 8'h80; step(1);
        check("R6 ready follows bit7", {31'd0, rdy_o}, 32'd1);
    endtask

    task automatic t_same_cycle();
        set_addr(11'h2AA, 11'h015);
        data_i = 8'h5D; we_n_i = 1'b0; step(4);
        addr_pins_i = 11'h155; rc_i = 1'b0; we_n_i = 1'b1; step(5);
        check("R9 write uses old address", {14'd0, wr_addr_cap}, {14'd0, 7'h15, 11'h2AA});
        do_write(8'h5E);
        check("R9 row update still lands", {14'd0, wr_addr_cap}, {14'd0, 7'h15, 11'h155});
        addr_pins_i = 11'h000; rc_i = 1'b1; step(4);
    endtask

    task automatic t_dormant();
        int w0;
        int r0;
        do_reset(1'b0);
        port_sel_i = 1'b1;
        w0 = wr_cnt; r0 = rd_cnt;
        status_i = 8'h00; step(2);
        check("R6 R7 dormant rdy stays high", {31'd0, rdy_o}, 32'd1);
        set_addr(11'h3, 11'h4);
        do_write(8'h77);
        oe_n_i = 1'b0; #1;
        check("R7 dormant no drive", {31'd0, data_oe_o}, 32'd0);
        step(5); oe_n_i = 1'b1; step(4);
        check("R7 dormant no write", wr_cnt - w0, 32'd0);
        check("R7 dormant no read", rd_cnt - r0, 32'd0);
        status_i = 8'h80;
        do_reset(1'b1);
        w0 = wr_cnt;
        port_sel_i = 1'b0; step(2);
        do_write(8'h21);
        check("R7 late select change ignored", wr_cnt - w0, 32'd1);
        port_sel_i = 1'b1;
    endtask

    initial begin
        step(2);
        t_reset_default();
        t_addr_halves();
        t_write_timing();
        t_read();
        t_orphan_rsp();
        t_ready();
        t_same_cycle();
        t_dormant();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule